// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog built on a binary counter. The counter advances on single-cycle enable ticks that arrive in the system clock domain. When it reaches the end of the selected period it raises a timeout and restarts from zero. Software sees two write-only registers. The control register holds the enable, the period, the tick source and the timeout route. The key register accepts a clear code, which restarts the counter, and a disable code.

The watchdog can only be turned off through a keyed three-write sequence: the clear code, then a control write with the enable bit at 0, then the disable code. Any other order leaves the watchdog running. While it is off, the counter is held at zero.

A timeout goes to one of two places. It can set a non-maskable interrupt request, which stays high until it is acknowledged. It can instead produce a one-cycle reset-request pulse. The period exponents are parameters. For a fast base of 25 and a slow base of 17, the four settings give 2^25, 2^23, 2^21 and 2^19 fast ticks, or 2^17, 2^15, 2^13 and 2^11 slow ticks.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset both outputs are low and the watchdog is running. Its defaults are period setting 00, the fast source and the reset-request route.
- R2: A control write (wr_sel=0) sets the following fields. Bit 0 is the enable. Bits 2:1 are the period setting p. Bit 3 selects the slow source when it is 1. Bit 4 routes the timeout to the reset request when it is 1. The timeout fires on the tick that completes 2^(FAST_EXP-2p) fast ticks, or 2^(SLOW_EXP-2p) slow ticks, counted after the counter was last cleared.
- R3: With bit 4 at 0, a timeout sets wdg_irq. wdg_irq stays high until irq_ack is pulsed, and it does not depend on any interrupt mask. The counter restarts from zero after each timeout.
- R4: Writing 0x4E to the key register (wr_sel=1) clears the counter.
- R5: The sequence 0x4E to the key register, then a control write with bit 0 at 0, then 0xB1 to the key register, stops the watchdog. After that no timeout occurs, whatever ticks arrive.
- R6: While the watchdog is stopped, the counter is held at zero. A control write with bit 0 at 1 restarts it, and a full period counts from that write.
- R7: A write that departs from the R5 order aborts the sequence and the watchdog keeps running. Examples are an enable-clearing write without the clear code before it, a different key value, a second control write, or the disable code alone.
- R8: With bit 4 at 1, a timeout drives wdg_rst_req high for exactly one cycle and leaves wdg_irq low.
- R9: Ticks of the source that is not selected do not advance the counter.
- R10: If the period is shortened while the count already exceeds the new limit, the next tick causes a timeout.
- R11: While slow_mode is high, the slow source and the slow periods are used, whatever bit 3 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = key register |
| wr_data | input | 8 | Write data |
| fast_tick | input | 1 | Fast-source count enable, one cycle per tick |
| slow_tick | input | 1 | Slow-source count enable, one cycle per tick |
| slow_mode | input | 1 | Forces the slow source and slow periods |
| irq_ack | input | 1 | Clears the held interrupt request |
| wdg_irq | output | 1 | Non-maskable timeout interrupt request (level) |
| wdg_rst_req | output | 1 | Timeout reset request (one-cycle pulse) |

## Verification
The checks assume that every period setting covers at least two ticks, so that timeouts can never fall on adjacent cycles. The reset-request pulse check relies on this. The stimulus keeps to it by using base exponents of 9 and 7, which give a shortest period of 8 or 2 ticks. Tick and write inputs are single-cycle strobes, driven away from the clock edge. The bench never asserts an acknowledge in the same cycle as a timeout, so the interrupt-hold property is only exercised where software would normally use it.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // key register codes
    localparam logic [7:0] KEY_CLEAR   = 8'h4E;
    localparam logic [7:0] KEY_DISABLE = 8'hB1;

    // register select on the write port
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_KEY  = 1'b1;

    // control register image: bit4 route, bit3 slow source, bits2:1 period, bit0 enable
    typedef struct packed {
        logic       route_rst;
        logic       slow_src;
        logic [1:0] period;
        logic       enable;
    } wdg_cfg_t;

    localparam wdg_cfg_t CFG_RESET = '{route_rst: 1'b1, slow_src: 1'b0, period: 2'b00, enable: 1'b1};

    // disable-sequence tracker
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_KEYED = 2'd1,
        SEQ_ARMED = 2'd2
    } seq_state_e;

    // each period step is a factor of four
    function automatic int period_exp(input int base, input logic [1:0] sel);
        return base - 2 * int'(sel);
    endfunction

endpackage

// File: rtl/wdg_keyseq.sv
module wdg_keyseq
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output wdg_cfg_t   cfg,
    output logic       clear_pulse
);

    seq_state_e state;
    logic       key_wr;
    logic       ctrl_wr;

    assign key_wr      = wr_en && (wr_sel == SEL_KEY);
    assign ctrl_wr     = wr_en && (wr_sel == SEL_CTRL);
    assign clear_pulse = key_wr && (wr_data == KEY_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= CFG_RESET;
            state <= SEQ_IDLE;
        end else if (key_wr) begin
            if (wr_data == KEY_CLEAR) begin
                state <= SEQ_KEYED;
            end else begin
                if (wr_data == KEY_DISABLE && state == SEQ_ARMED)
                    cfg.enable <= 1'b0;
                state <= SEQ_IDLE;
            end
        end else if (ctrl_wr) begin
            cfg.route_rst <= wr_data[4];
            cfg.slow_src  <= wr_data[3];
            cfg.period    <= wr_data[2:1];
            // a running watchdog only stops through the keyed sequence
            if (!cfg.enable)
                cfg.enable <= wr_data[0];
            if (cfg.enable && !wr_data[0] && state == SEQ_KEYED)
                state <= SEQ_ARMED;
            else
                state <= SEQ_IDLE;
        end
    end

    // R5
    enable_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg.enable) |-> $past(key_wr && wr_data == KEY_DISABLE));

    // R7
    armed_origin_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_ARMED && !$stable(state)) |-> $past(state == SEQ_KEYED && ctrl_wr));

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int FAST_EXP = 25,
    parameter int SLOW_EXP = 17,
    parameter int CNT_W    = 25
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       clear,
    input  logic       fast_tick,
    input  logic       slow_tick,
    input  logic       slow_mode,
    input  logic       slow_src,
    input  logic [1:0] period,
    output logic       overflow
);

    logic [CNT_W-1:0] lim_tab [2][4];
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             use_slow;
    logic             tick;
    logic             at_end;

    for (genvar s = 0; s < 2; s++) begin : g_src
        for (genvar p = 0; p < 4; p++) begin : g_per
            localparam int EXP = period_exp((s == 1) ? SLOW_EXP : FAST_EXP, 2'(p));
            assign lim_tab[s][p] = CNT_W'((64'd1 << EXP) - 64'd1);
        end
    end

    assign use_slow = slow_src | slow_mode;
    assign tick     = use_slow ? slow_tick : fast_tick;
    assign lim      = lim_tab[use_slow][period];
    assign at_end   = (cnt >= lim);
    assign overflow = enable && !clear && tick && at_end;

    always_ff @(posedge clk) begin
        if (rst || !enable || clear)
            cnt <= '0;
        else if (tick)
            cnt <= at_end ? '0 : cnt + 1'b1;
    end

    // R6
    hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> cnt == '0);

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> cnt == '0);

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> cnt == '0);

endmodule

// File: rtl/wdg_output.sv
module wdg_output (
    input  logic clk,
    input  logic rst,
    input  logic overflow,
    input  logic route_rst,
    input  logic irq_ack,
    output logic irq,
    output logic rst_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= overflow && route_rst;
            if (overflow && !route_rst)
                irq <= 1'b1;
            else if (irq_ack)
                irq <= 1'b0;
        end
    end

    // R3
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_ack) |=> irq);

    // R8
    rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R8
    route_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !($rose(irq) && rst_req));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int FAST_EXP = 25,
    parameter int SLOW_EXP = 17
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       fast_tick,
    input  logic       slow_tick,
    input  logic       slow_mode,
    input  logic       irq_ack,
    output logic       wdg_irq,
    output logic       wdg_rst_req
);

    localparam int CNT_W = (FAST_EXP > SLOW_EXP) ? FAST_EXP : SLOW_EXP;

    wdg_cfg_t cfg;
    logic     clear_pulse;
    logic     overflow;

    wdg_keyseq u_keyseq (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .cfg         (cfg),
        .clear_pulse (clear_pulse)
    );

    wdg_counter #(
        .FAST_EXP (FAST_EXP),
        .SLOW_EXP (SLOW_EXP),
        .CNT_W    (CNT_W)
    ) u_counter (
        .clk       (clk),
        .rst       (rst),
        .enable    (cfg.enable),
        .clear     (clear_pulse),
        .fast_tick (fast_tick),
        .slow_tick (slow_tick),
        .slow_mode (slow_mode),
        .slow_src  (cfg.slow_src),
        .period    (cfg.period),
        .overflow  (overflow)
    );

    wdg_output u_output (
        .clk       (clk),
        .rst       (rst),
        .overflow  (overflow),
        .route_rst (cfg.route_rst),
        .irq_ack   (irq_ack),
        .irq       (wdg_irq),
        .rst_req   (wdg_rst_req)
    );

endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;

    localparam int FE = 9;
    localparam int SE = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       fast_tick = 1'b0;
    logic       slow_tick = 1'b0;
    logic       slow_mode = 1'b0;
    logic       irq_ack = 1'b0;
    logic       wdg_irq;
    logic       wdg_rst_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    keyed_watchdog #(.FAST_EXP(FE), .SLOW_EXP(SE)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .fast_tick(fast_tick), .slow_tick(slow_tick), .slow_mode(slow_mode),
        .irq_ack(irq_ack), .wdg_irq(wdg_irq), .wdg_rst_req(wdg_rst_req)
    );

    function automatic int period_of(input int slow, input int sel);
        return 1 << ((slow != 0 ? SE : FE) - 2 * sel);
    endfunction

    function automatic logic [7:0] ctl(input bit route, input bit slow, input int sel, input bit en);
        return {3'b000, route, slow, 2'(sel), en};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input bit sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int slow, input int n);
        for (int i = 0; i < n; i++) begin
            if (slow != 0) slow_tick = 1'b1; else fast_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0; fast_tick = 1'b0;
        end
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: outputs low after reset, default fast 00 period routed to reset request
        chk("R1 irq after reset", wdg_irq, 0);
        chk("R1 rst_req after reset", wdg_rst_req, 0);
        ticks(0, period_of(0, 0) - 1);
        chk("R1 default no early timeout", wdg_rst_req, 0);
        ticks(0, 1);
        chk("R1 default timeout on reset route", wdg_rst_req, 1);
        chk("R1 default irq stays low", wdg_irq, 0);
        @(negedge clk);
        chk("R8 reset pulse one cycle", wdg_rst_req, 0);

        // R2 / R9: sweep every source and period setting
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 4; p++) begin
                wr(1'b0, ctl(1'b0, 1'(s), p, 1'b1));
                wr(1'b1, 8'h4E);
                ticks(1 - s, 600);
                chk($sformatf("R9 other source ignored s=%0d p=%0d", s, p), wdg_irq, 0);
                ticks(s, period_of(s, p) - 1);
                chk($sformatf("R2 no early timeout s=%0d p=%0d", s, p), wdg_irq, 0);
                ticks(s, 1);
                chk($sformatf("R2 timeout at period s=%0d p=%0d", s, p), wdg_irq, 1);
                ack();
                chk($sformatf("R3 ack clears s=%0d p=%0d", s, p), wdg_irq, 0);
            end
        end

        // R3: level held, counter restarts from zero
        wr(1'b0, ctl(1'b0, 1'b0, 3, 1'b1));
        wr(1'b1, 8'h4E);
        ticks(0, 8);
        repeat (20) @(negedge clk);
        chk("R3 irq held without ack", wdg_irq, 1);
        ack();
        ticks(0, 7);
        chk("R3 restart no early timeout", wdg_irq, 0);
        ticks(0, 1);
        chk("R3 restart full period", wdg_irq, 1);
        ack();

        // R4: clear code restarts the count
        ticks(0, 5);
        wr(1'b1, 8'h4E);
        ticks(0, 7);
        chk("R4 clear restarts count", wdg_irq, 0);
        ticks(0, 1);
        chk("R4 timeout after clear", wdg_irq, 1);
        ack();

        // R5: correct keyed disable
        wr(1'b1, 8'h4E);
        wr(1'b0, ctl(1'b0, 1'b0, 3, 1'b0));
        wr(1'b1, 8'hB1);
        ticks(0, 600);
        ticks(1, 600);
        chk("R5 disabled no irq", wdg_irq, 0);
        chk("R5 disabled no rst_req", wdg_rst_req, 0);

        // R6: re-enable counts a full period from zero
        wr(1'b0, ctl(1'b0, 1'b0, 3, 1'b1));
        ticks(0, 7);
        chk("R6 re-enabled from zero", wdg_irq, 0);
        ticks(0, 1);
        chk("R6 re-enabled timeout", wdg_irq, 1);
        ack();

        // R7: broken sequences keep the watchdog running
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: begin wr(1'b0, ctl(1'b0, 1'b0, 3, 1'b0)); wr(1'b1, 8'hB1); end
                1: begin wr(1'b1, 8'h4E); wr(1'b0, ctl(1'b0, 1'b0, 3, 1'b0)); wr(1'b1, 8'h55); end
                2: begin wr(1'b1, 8'h4E); wr(1'b1, 8'h12); wr(1'b0, ctl(1'b0, 1'b0, 3, 1'b0)); wr(1'b1, 8'hB1); end
                3: begin wr(1'b1, 8'h4E); wr(1'b0, ctl(1'b0, 1'b0, 3, 1'b0)); wr(1'b0, ctl(1'b0, 1'b0, 3, 1'b0)); wr(1'b1, 8'hB1); end
                4: begin wr(1'b1, 8'hB1); end
                default: begin wr(1'b1, 8'h4E); wr(1'b1, 8'hB1); end
            endcase
            wr(1'b1, 8'h4E);
            ticks(0, 8);
            chk($sformatf("R7 still running case %0d", k), wdg_irq, 1);
            ack();
        end

        // R10: shortening the period past the count
        wr(1'b0, ctl(1'b0, 1'b0, 0, 1'b1));
        wr(1'b1, 8'h4E);
        ticks(0, 100);
        chk("R10 long period running", wdg_irq, 0);
        wr(1'b0, ctl(1'b0, 1'b0, 3, 1'b1));
        ticks(0, 1);
        chk("R10 next tick times out", wdg_irq, 1);
        ack();

        // R11: slow_mode forces the slow source
        slow_mode = 1'b1;
        wr(1'b1, 8'h4E);
        ticks(0, 100);
        chk("R11 fast ticks ignored", wdg_irq, 0);
        ticks(1, period_of(1, 3) - 1);
        chk("R11 slow no early timeout", wdg_irq, 0);
        ticks(1, 1);
        chk("R11 slow period timeout", wdg_irq, 1);
        ack();
        slow_mode = 1'b0;

        // R8: reset-request route
        wr(1'b0, ctl(1'b1, 1'b0, 3, 1'b1));
        wr(1'b1, 8'h4E);
        ticks(0, 7);
        chk("R8 no early reset request", wdg_rst_req, 0);
        ticks(0, 1);
        chk("R8 reset request raised", wdg_rst_req, 1);
        chk("R8 irq stays low", wdg_irq, 0);
        @(negedge clk);
        chk("R8 reset request one cycle", wdg_rst_req, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule